// File: doc/BRIEF.md
# SPI Flash Status Register Emulator

This block holds the three 8-bit status registers that a device posing as a serial flash shows to an external host. Each register lives in the serial-clock domain. Software in the system-clock domain writes a whole register at a time. Each write passes through a small asynchronous queue into a staging bank. Staged contents move into the committed bank, which is what the host sees, at every byte boundary of the serial clock. A host that keeps chip select low while it polls the busy bit therefore sees that bit change without ending its transaction.

An upstream decoder presents each command as a single-cycle strobe together with a command code. The strobe is sampled on the rising serial-clock edge that completes the opcode byte. A read-status command returns the addressed register again and again for as long as chip select stays low. The write-enable set and clear commands change the write-enable latch bit directly, and take priority over any staged software value for that bit. Serial data is shifted out MSB first on falling edges.

Two further behaviours are covered. A software write that finds the queue full is discarded and recorded in a sticky flag. A separate pass-through gate enable follows its request input only when chip select rises.

Top module: `flash_status_emu`

## Requirements
- R1: After reset all three registers read 0x00, `sw_drop_flag` is 0, `gate_en` is 0 and `so` is 0.
- R2: Command codes 0, 1 and 2 read status registers 1, 2 and 3. Each returns only its own register, MSB first, repeated for every byte while `csb` stays low.
- R3: `sw_wr_sel` values 0, 1 and 2 address registers 1, 2 and 3. A software write made while the serial clock is idle during a held-low poll does not show in the next byte read. It shows from the byte after that, with no rise of `csb`.
- R4: Command code 3 (write enable) sets bit 1 of register 1 in the first data byte after the command, even if a staged software value for that bit is 0. Bit 0 (busy) of register 1 follows the software value.
- R5: Command code 4 (write disable) clears bit 1 of register 1, even if a staged software value for that bit is 1.
- R6: The queue holds `FIFO_DEPTH` (default 4) writes. A write that finds it full is discarded, never reaches a register, and sets `sw_drop_flag`, which stays set.
- R7: A pulse on `sw_drop_clr` with no dropped write in the same cycle clears `sw_drop_flag` on the next system clock.
- R8: `gate_en` takes the value of `gate_req` only when `csb` rises. It never changes while `csb` is low.
- R9: The bit counter that marks byte boundaries is zero whenever `csb` is high. A transaction aborted after a partial byte does not misalign the next read.
- R10: `so` is 0 while `csb` is high, during every opcode byte, and after any command other than a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the software write port |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sw_wr_valid | input | 1 | Software write strobe |
| sw_wr_sel | input | 2 | Register select: 0, 1, 2 for registers 1, 2, 3 |
| sw_wr_data | input | 8 | Full register value to stage |
| sw_drop_clr | input | 1 | Write-one-to-clear for the drop flag |
| sw_drop_flag | output | 1 | Sticky flag: a software write was discarded |
| sck | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low chip select |
| cmd_valid | input | 1 | Decoded command strobe, sampled on the last opcode rising edge |
| cmd_op | input | 3 | Command code: 0-2 read register 1-3, 3 write enable, 4 write disable |
| so | output | 1 | Serial read data |
| gate_req | input | 1 | Requested pass-through gate state |
| gate_en | output | 1 | Pass-through gate enable, updated on `csb` rise |

## Verification
On every cycle, the assertions check the drop flag's set and clear rules, the gate enable holding still while `csb` is low, the idle output and counter while deselected, and the write-enable bit after each enable or disable strobe. Only the bench scenarios show things that depend on whole byte sequences. These are which byte of a held-low poll first carries a software update, that read commands never rotate registers, that a dropped write never appears, and that a torn transaction leaves later reads aligned.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;

    // bit positions inside status register 1
    localparam int WIP_BIT = 0;
    localparam int WEL_BIT = 1;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RD1  = 3'd0,
        OP_RD2  = 3'd1,
        OP_RD3  = 3'd2,
        OP_WREN = 3'd3,
        OP_WRDI = 3'd4
    } op_e;

endpackage

// File: rtl/flash_status_swq.sv
`timescale 1ns/1ps
// Short dual-clock queue: software writes enter on sys_clk and are popped
// one per sck rising edge. Writes into a full queue are discarded and flagged.
module flash_status_swq #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4
) (
    input  logic              sys_clk,
    input  logic              sck,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              drop_clr,
    output logic              drop_flag,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_XOR = PW'(3) << (PW - 2);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wbin;
        logic [PW-1:0]                wgray;
        logic [PW-1:0]                rs1;
        logic [PW-1:0]                rs2;
        logic                         drop;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic [PW-1:0] ws1;
        logic [PW-1:0] ws2;
    } rside_t;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    wside_t w_d, w_q;
    rside_t r_d, r_q;
    logic   full;
    logic   empty;

    // write side, system clock
    always_comb begin
        w_d     = w_q;
        w_d.rs1 = r_q.rgray;
        w_d.rs2 = w_q.rs1;
        full    = ((w_q.wgray ^ w_q.rs2) == FULL_XOR);
        if (wr_valid && !full) begin
            w_d.mem[w_q.wbin[AW-1:0]] = wr_data;
            w_d.wbin  = w_q.wbin + 1'b1;
            w_d.wgray = to_gray(w_d.wbin);
        end
        w_d.drop = (wr_valid && full) || (w_q.drop && !drop_clr);
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // read side, serial clock: pop whenever something is visible
    always_comb begin
        r_d     = r_q;
        r_d.ws1 = w_q.wgray;
        r_d.ws2 = r_q.ws1;
        empty   = (r_q.rgray == r_q.ws2);
        if (!empty) begin
            r_d.rbin  = r_q.rbin + 1'b1;
            r_d.rgray = to_gray(r_d.rbin);
        end
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign drop_flag = w_q.drop;
    assign rd_valid  = !empty;
    assign rd_data   = w_q.mem[r_q.rbin[AW-1:0]];

endmodule

// File: rtl/flash_status_core.sv
`timescale 1ns/1ps
// Serial-clock side: staging bank, committed bank, byte counter, read shifter.
module flash_status_core
    import flash_status_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 3,
    parameter int SEL_W    = 2
) (
    input  logic                     sck,
    input  logic                     csb,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [OP_W-1:0]          cmd_op,
    input  logic                     upd_valid,
    input  logic [SEL_W+REG_W-1:0]   upd_data,
    output logic                     so,
    output logic [REG_W-1:0]         reg1_o,
    output logic [$clog2(REG_W)-1:0] byte_pos_o
);

    localparam int BCW = $clog2(REG_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(REG_W - 1);

    typedef logic [NUM_REGS-1:0][REG_W-1:0] bank_t;

    typedef struct packed {
        bank_t staged;
        bank_t committed;
    } core_t;

    typedef struct packed {
        logic [BCW-1:0]   cnt;
        logic             active;
        logic [SEL_W-1:0] sel;
    } xfer_t;

    core_t          core_d, core_q;
    xfer_t          xfer_d, xfer_q;
    logic [REG_W-1:0] sh_d, sh_q;

    logic             xfer_arst;
    logic [SEL_W-1:0] upd_sel;
    logic [REG_W-1:0] upd_val;
    logic             hw_hit;
    logic             hw_val;
    bank_t            stage;

    assign xfer_arst = !rst_n || csb;
    assign upd_sel   = upd_data[REG_W +: SEL_W];
    assign upd_val   = upd_data[REG_W-1:0];
    assign hw_hit    = cmd_valid && (cmd_op == OP_WREN || cmd_op == OP_WRDI);
    assign hw_val    = (cmd_op == OP_WREN);

    // staged value is formed here so a hardware update overrides it in-cycle
    always_comb begin
        stage = core_q.staged;
        if (upd_valid && int'(upd_sel) < NUM_REGS)
            stage[upd_sel] = upd_val;
        if (hw_hit)
            stage[0][WEL_BIT] = hw_val;

        core_d.staged    = stage;
        core_d.committed = (xfer_q.cnt == LAST_BIT) ? stage : core_q.committed;
        if (hw_hit)
            core_d.committed[0][WEL_BIT] = hw_val;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    // per-transaction state, cleared while chip select is high
    always_comb begin
        xfer_d     = xfer_q;
        xfer_d.cnt = xfer_q.cnt + 1'b1;
        if (cmd_valid) begin
            xfer_d.active = (int'(cmd_op) < NUM_REGS);
            xfer_d.sel    = cmd_op[SEL_W-1:0];
        end
    end

    always_ff @(posedge sck or posedge xfer_arst) begin
        if (xfer_arst) xfer_q <= '0;
        else           xfer_q <= xfer_d;
    end

    // falling-edge shifter: reload on the first bit of each byte
    always_comb begin
        if (xfer_q.cnt == '0)
            sh_d = (int'(xfer_q.sel) < NUM_REGS) ? core_q.committed[xfer_q.sel] : '0;
        else
            sh_d = sh_q << 1;
    end

    always_ff @(negedge sck or posedge xfer_arst) begin
        if (xfer_arst) sh_q <= '0;
        else           sh_q <= sh_d;
    end

    assign so         = xfer_q.active && sh_q[REG_W-1];
    assign reg1_o     = core_q.committed[0];
    assign byte_pos_o = xfer_q.cnt;

endmodule

// File: rtl/flash_status_gate.sv
`timescale 1ns/1ps
// Pass-through gate enable: follows its request only at chip-select rise.
module flash_status_gate (
    input  logic csb,
    input  logic rst_n,
    input  logic gate_req,
    output logic gate_en
);

    logic gate_d, gate_q;

    always_comb gate_d = gate_req;

    always_ff @(posedge csb or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign gate_en = gate_q;

endmodule

// File: rtl/flash_status_emu.sv
`timescale 1ns/1ps
module flash_status_emu
    import flash_status_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int NUM_REGS   = 3,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            sys_clk,
    input  logic                            rst_n,
    input  logic                            sw_wr_valid,
    input  logic [$clog2(NUM_REGS+1)-1:0]   sw_wr_sel,
    input  logic [REG_W-1:0]                sw_wr_data,
    input  logic                            sw_drop_clr,
    output logic                            sw_drop_flag,
    input  logic                            sck,
    input  logic                            csb,
    input  logic                            cmd_valid,
    input  logic [OP_W-1:0]                 cmd_op,
    output logic                            so,
    input  logic                            gate_req,
    output logic                            gate_en
);

    localparam int SEL_W = $clog2(NUM_REGS + 1);
    localparam int BCW   = $clog2(REG_W);
    localparam int ENT_W = SEL_W + REG_W;

    logic             upd_valid;
    logic [ENT_W-1:0] upd_data;
    logic [REG_W-1:0] status1_w;
    logic [BCW-1:0]   byte_pos_w;

    flash_status_swq #(
        .DATA_W (ENT_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_swq (
        .sys_clk   (sys_clk),
        .sck       (sck),
        .rst_n     (rst_n),
        .wr_valid  (sw_wr_valid),
        .wr_data   ({sw_wr_sel, sw_wr_data}),
        .drop_clr  (sw_drop_clr),
        .drop_flag (sw_drop_flag),
        .rd_valid  (upd_valid),
        .rd_data   (upd_data)
    );

    flash_status_core #(
        .REG_W    (REG_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_core (
        .sck        (sck),
        .csb        (csb),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .upd_valid  (upd_valid),
        .upd_data   (upd_data),
        .so         (so),
        .reg1_o     (status1_w),
        .byte_pos_o (byte_pos_w)
    );

    flash_status_gate u_gate (
        .csb      (csb),
        .rst_n    (rst_n),
        .gate_req (gate_req),
        .gate_en  (gate_en)
    );

endmodule

// File: rtl/flash_status_chk.sv
`timescale 1ns/1ps
module flash_status_chk
    import flash_status_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int BCW   = 3
) (
    input logic             sys_clk,
    input logic             sck,
    input logic             rst_n,
    input logic             csb,
    input logic             so,
    input logic             sw_wr_valid,
    input logic             sw_drop_clr,
    input logic             sw_drop_flag,
    input logic             gate_en,
    input logic             cmd_valid,
    input logic [OP_W-1:0]  cmd_op,
    input logic [REG_W-1:0] reg1,
    input logic [BCW-1:0]   byte_pos
);

    // R6
    drop_needs_write_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(sw_drop_flag) |-> $past(sw_wr_valid));

    // R7
    drop_clear_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (sw_drop_clr && !sw_wr_valid) |=> !sw_drop_flag);

    // R8
    gate_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !$stable(gate_en) |-> csb);

    // R10
    idle_out_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        csb |-> !so);

    // R9
    idle_count_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        csb |-> (byte_pos == '0));

    // R4
    wel_set_chk: assert property (@(posedge sck) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WREN) |=> reg1[WEL_BIT]);

    // R5
    wel_clear_chk: assert property (@(posedge sck) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRDI) |=> !reg1[WEL_BIT]);

endmodule

bind flash_status_emu flash_status_chk #(
    .REG_W (REG_W),
    .BCW   (BCW)
) u_chk (
    .sys_clk      (sys_clk),
    .sck          (sck),
    .rst_n        (rst_n),
    .csb          (csb),
    .so           (so),
    .sw_wr_valid  (sw_wr_valid),
    .sw_drop_clr  (sw_drop_clr),
    .sw_drop_flag (sw_drop_flag),
    .gate_en      (gate_en),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .reg1         (status1_w),
    .byte_pos     (byte_pos_w)
);

// File: tb/sim_flash_status_emu.sv
`timescale 1ns/1ps
module sim_flash_status_emu;
    import flash_status_pkg::*;

    logic       sys_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr_valid = 1'b0;
    logic [1:0] sw_wr_sel = '0;
    logic [7:0] sw_wr_data = '0;
    logic       sw_drop_clr = 1'b0;
    logic       sw_drop_flag;
    logic       sck = 1'b0;
    logic       csb = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic       so;
    logic       gate_req = 1'b0;
    logic       gate_en;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #2 sys_clk = ~sys_clk;   // 250 MHz

    flash_status_emu u0 (
        .sys_clk      (sys_clk),
        .rst_n        (rst_n),
        .sw_wr_valid  (sw_wr_valid),
        .sw_wr_sel    (sw_wr_sel),
        .sw_wr_data   (sw_wr_data),
        .sw_drop_clr  (sw_drop_clr),
        .sw_drop_flag (sw_drop_flag),
        .sck          (sck),
        .csb          (csb),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .so           (so),
        .gate_req     (gate_req),
        .gate_en      (gate_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one host byte; samples so just before each rising edge
    task automatic host_xfer(input logic is_cmd, input logic [2:0] op, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < 8; i++) begin
            cmd_valid = is_cmd && (i == 7);
            cmd_op    = op;
            #10;
            rx  = {rx[6:0], so};
            sck = 1'b1;
            #10;
            sck = 1'b0;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic host_cmd(input logic [2:0] op);
        logic [7:0] rx;
        host_xfer(1'b1, op, rx);
        check("R10 so low in opcode byte", rx, 8'h00);
    endtask

    // driver side of the scoreboard
    task automatic host_poll(input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_xfer(1'b0, 3'd0, rx);
        obs_q.push_back(rx);
    endtask

    task automatic sel_lo();
        #7 csb = 1'b0;
        #10;
    endtask

    task automatic sel_hi();
        #10 csb = 1'b1;
        #20;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge sys_clk);
        sw_wr_valid = 1'b1;
        sw_wr_sel   = sel;
        sw_wr_data  = val;
        @(negedge sys_clk);
        sw_wr_valid = 1'b0;
        repeat (3) @(negedge sys_clk);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            logic [7:0] o, e;
            string t;
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, o, e);
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge sys_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge sys_clk);

        // R1 reset state
        check("R1 drop flag", {7'b0, sw_drop_flag}, 8'h00);
        check("R1 gate_en", {7'b0, gate_en}, 8'h00);
        check("R1 so", {7'b0, so}, 8'h00);
        sel_lo(); host_cmd(OP_RD1); host_poll(8'h00, "R1 reg1"); sel_hi();
        sel_lo(); host_cmd(OP_RD2); host_poll(8'h00, "R1 reg2"); sel_hi();
        sel_lo(); host_cmd(OP_RD3); host_poll(8'h00, "R1 reg3"); sel_hi();

        // R2 each read returns only its own register, repeated
        sw_write(2'd0, 8'h01);
        sw_write(2'd1, 8'hA5);
        sw_write(2'd2, 8'h3C);
        sel_lo(); host_cmd(OP_RD2);
        host_poll(8'hA5, "R2 reg2 byte0");
        host_poll(8'hA5, "R2 reg2 byte1");
        host_poll(8'hA5, "R2 reg2 byte2");
        sel_hi();
        sel_lo(); host_cmd(OP_RD3);
        host_poll(8'h3C, "R2 reg3 byte0");
        host_poll(8'h3C, "R2 reg3 byte1");
        sel_hi();
        sel_lo(); host_cmd(OP_RD1);
        host_poll(8'h01, "R2 reg1 byte0");
        host_poll(8'h01, "R2 reg1 byte1");
        sel_hi();

        // R3 busy clear seen during a held-low poll
        sel_lo(); host_cmd(OP_RD1);
        host_poll(8'h01, "R3 before write");
        sw_write(2'd0, 8'h00);
        #20;
        host_poll(8'h01, "R3 byte after write still old");
        host_poll(8'h00, "R3 second byte shows clear");
        host_poll(8'h00, "R3 third byte");
        check("R10 so low after read ends", {7'b0, so}, 8'h00);
        sel_hi();
        check("R10 so low while deselected", {7'b0, so}, 8'h00);

        // R4 write enable beats pending staged WEL=0
        sw_write(2'd0, 8'h01);
        sel_lo(); host_cmd(OP_WREN);
        check("R10 so low after write-enable", {7'b0, so}, 8'h00);
        sel_hi();
        sel_lo(); host_cmd(OP_RD1);
        host_poll(8'h03, "R4 WEL set byte0");
        host_poll(8'h03, "R4 WEL set byte1");
        sel_hi();

        // R5 write disable beats pending staged WEL=1
        sw_write(2'd0, 8'h03);
        sel_lo(); host_cmd(OP_WRDI); sel_hi();
        sel_lo(); host_cmd(OP_RD1);
        host_poll(8'h01, "R5 WEL clear byte0");
        host_poll(8'h01, "R5 WEL clear byte1");
        sel_hi();

        // R6 overflow drops the fifth write
        sw_write(2'd2, 8'h11);
        sw_write(2'd2, 8'h22);
        sw_write(2'd2, 8'h33);
        sw_write(2'd2, 8'h44);
        check("R6 no drop at depth", {7'b0, sw_drop_flag}, 8'h00);
        sw_write(2'd2, 8'h55);
        check("R6 drop flagged", {7'b0, sw_drop_flag}, 8'h01);
        sel_lo(); host_cmd(OP_RD3);
        host_poll(8'h44, "R6 dropped value absent");
        sel_hi();
        check("R6 flag sticky", {7'b0, sw_drop_flag}, 8'h01);

        // R7 clear
        @(negedge sys_clk); sw_drop_clr = 1'b1;
        @(negedge sys_clk); sw_drop_clr = 1'b0;
        check("R7 flag cleared", {7'b0, sw_drop_flag}, 8'h00);

        // R8 gate follows request only at chip-select rise
        sel_lo();
        gate_req = 1'b1;
        #40;
        check("R8 gate held while selected", {7'b0, gate_en}, 8'h00);
        sel_hi();
        check("R8 gate on at rise", {7'b0, gate_en}, 8'h01);
        gate_req = 1'b0;
        #40;
        check("R8 gate held while idle", {7'b0, gate_en}, 8'h01);
        sel_lo(); sel_hi();
        check("R8 gate off at rise", {7'b0, gate_en}, 8'h00);

        // R9 torn transaction does not misalign the next read
        sel_lo();
        for (int i = 0; i < 3; i++) begin
            #10 sck = 1'b1;
            #10 sck = 1'b0;
        end
        sel_hi();
        sel_lo(); host_cmd(OP_RD2);
        host_poll(8'hA5, "R9 aligned after abort");
        sel_hi();
        sel_lo(); host_cmd(OP_RD1);
        host_poll(8'h01, "R9 reg1 aligned");
        sel_hi();

        wait (obs_q.size() == 0);
        #20;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule